// File: doc/BRIEF.md
# Interleaved Flash Command Formatter

This block prepares one write cycle for a bank of parallel NOR devices that share a single data bus. Given an 8-bit command byte and a command offset, it produces the bus address the command must go to and the full-width data word that places the command in every device lane. From the same strobe it also takes a status word read back from the bus and folds it down to a single per-device status value. It only prepares these values. Issuing the bus cycles and decoding the status bits are done elsewhere.

The geometry comes from configuration inputs: bus width in bytes, the number of interleaved devices, the device width in bytes, and a byte-order select. The lane width is the bus width divided by the interleave. The machine word is WORD_BYTES wide. A bus wider than one machine word is handled as several sub-words. All results are registered on the cycle a request strobe is sampled.

A two-state controller sequences the response. S_IDLE is the rest state. The transition "accept" takes it to S_DONE whenever the strobe is sampled. In S_DONE the response valid is high for that one cycle. From S_DONE, "re-accept" stays in S_DONE on a back-to-back strobe, and "retire" returns to S_IDLE when there is no strobe.

Top module: `flash_cmd_fmt`

## Requirements
- R1: After reset, rsp_valid, geom_err, addr_out, data_out and status_out are all zero.
- R2: A strobe sampled on a rising edge makes rsp_valid high for the following cycle, and the outputs show the result for the inputs sampled on that edge. Without a strobe, rsp_valid is low and all outputs hold their values, whatever the other inputs do.
- R3: On a legal geometry, addr_out equals cmd_ofs × device width × interleave.
- R4: When device width × interleave exceeds bus width and cmd_ofs[7:0] is 0xAA, the value (device width / 2) × interleave is ORed into addr_out.
- R5: The geometry is legal only when all of these hold: bus width is 1, 2, 4, 8 or 16; interleave is 1, 2, 4 or 8 and does not exceed bus width; bus width / interleave is 1, 2 or 4; device width is 1, 2 or 4. On any other geometry, geom_err is 1 and addr_out, data_out and status_out are zero.
- R6: With little-endian select (cfg_big_end = 0), or with 1-byte lanes, every lane of data_out carries the command in its lowest-addressed byte and zeros in its other bytes. The lowest-addressed byte is bit 7:0 of the lane. data_out bytes at or above the bus width are zero.
- R7: With big-endian select (cfg_big_end = 1) and 2- or 4-byte lanes, every lane carries the command in its highest byte and zeros in its other bytes.
- R8: When the bus is wider than one machine word, every sub-word of data_out carries the same replicated command.
- R9: status_out begins from S, which is the OR of the bus bytes placed at their positions modulo the machine-word width. Let the lane count L be the machine-word-limited width divided by the lane width. Then S is ORed with S>>(lane bits×4) if L ≥ 8, with S>>(lane bits×2) if L ≥ 4, and with S>>(lane bits) if L ≥ 2. For 1-byte lanes, the full word is returned.
- R10: For 2-byte lanes, status_out is the low 16 bits of the folded value, zero-extended. For 4-byte lanes it is the low 32 bits, zero-extended. In both cases the bytes are swapped when cfg_big_end = 1.
- R11: status_in bytes at or above the bus width have no effect on status_out. For a bus wider than one machine word, all sub-words are ORed before folding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| cmd | input | 8 | Command byte |
| cmd_ofs | input | OFS_W | Command offset in device words |
| cfg_bus_bytes | input | clog2(MAX_BUS_BYTES)+1 | Bus width in bytes |
| cfg_ilv | input | 4 | Interleave count |
| cfg_dev_bytes | input | 3 | Device width in bytes |
| cfg_big_end | input | 1 | Device byte order, 1 = big-endian |
| status_in | input | MAX_BUS_BYTES*8 | Status word read from the bus |
| rsp_valid | output | 1 | Result valid pulse |
| addr_out | output | ADDR_W | Formatted command address |
| data_out | output | MAX_BUS_BYTES*8 | Replicated command word |
| status_out | output | WORD_BYTES*8 | Merged per-device status |
| geom_err | output | 1 | Illegal geometry flag |

## Verification
Two events can meet in one cycle. The first is a new strobe arriving while the previous response is still showing (the re-accept transition). The bench provokes this with back-to-back strobes that change geometry and byte order each time, and judges every cycle against a behavioural model. The second case is a single strobe that exercises the address twist, lane replication and status folding together with independent inputs. Random idle cycles that change every input confirm the hold behaviour.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } fcf_state_e;

    typedef struct packed {
        logic       ok;
        logic [2:0] lg;
    } pow2_t;

    // decode a power of two up to 16 into its log2
    function automatic pow2_t pow2_decode(input logic [4:0] v);
        pow2_t r;
        r.ok = 1'b1;
        r.lg = 3'd0;
        case (v)
            5'd1:    r.lg = 3'd0;
            5'd2:    r.lg = 3'd1;
            5'd4:    r.lg = 3'd2;
            5'd8:    r.lg = 3'd3;
            5'd16:   r.lg = 3'd4;
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcf_geom.sv
module fcf_geom
    import fcf_pkg::*;
#(
    parameter int MAX_BUS_BYTES = 16,
    parameter int WORD_BYTES    = 8
) (
    input  logic [$clog2(MAX_BUS_BYTES):0] bus_bytes,
    input  logic [3:0]                     ilv,
    input  logic [2:0]                     dev_bytes,
    output logic                           legal,
    output logic [2:0]                     bus_lg,
    output logic [2:0]                     ilv_lg,
    output logic [2:0]                     dev_lg,
    output logic [2:0]                     lane_lg,
    output logic [2:0]                     lanes_lg,
    output logic [2:0]                     sub_lg
);
    localparam int WORD_LG = $clog2(WORD_BYTES);
    localparam int MAX_LG  = $clog2(MAX_BUS_BYTES);

    pow2_t      b_d, i_d, d_d;
    logic [2:0] word_lg;

    always_comb begin
        b_d = pow2_decode(5'(bus_bytes));
        i_d = pow2_decode({1'b0, ilv});
        d_d = pow2_decode({2'b00, dev_bytes});
        bus_lg  = b_d.lg;
        ilv_lg  = i_d.lg;
        dev_lg  = d_d.lg;
        lane_lg = b_d.lg - i_d.lg;
        word_lg = (b_d.lg > 3'(WORD_LG)) ? 3'(WORD_LG) : b_d.lg;
        lanes_lg = word_lg - lane_lg;
        sub_lg   = b_d.lg - word_lg;
        legal = b_d.ok && (b_d.lg <= 3'(MAX_LG)) &&
                i_d.ok && (i_d.lg <= 3'd3) &&
                d_d.ok && (d_d.lg <= 3'd2) &&
                (b_d.lg >= i_d.lg) && (lane_lg <= 3'd2);
    end
endmodule

// File: rtl/fcf_addr.sv
module fcf_addr #(
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [2:0]        bus_lg,
    input  logic [2:0]        ilv_lg,
    input  logic [2:0]        dev_lg,
    output logic [ADDR_W-1:0] addr
);
    logic [3:0]        scale_lg;
    logic [ADDR_W-1:0] base, twist;
    logic              compat;

    always_comb begin
        scale_lg = {1'b0, dev_lg} + {1'b0, ilv_lg};
        base     = ADDR_W'(ofs) << scale_lg;
        compat   = (scale_lg > {1'b0, bus_lg}) && (ofs[7:0] == 8'hAA);
        twist    = ((ADDR_W'(1) << dev_lg) >> 1) << ilv_lg;
        addr     = compat ? (base | twist) : base;
    end
endmodule

// File: rtl/fcf_cmd.sv
module fcf_cmd #(
    parameter int MAX_BUS_BYTES = 16,
    parameter int WORD_BYTES    = 8
) (
    input  logic [7:0]                   cmd,
    input  logic                         big_end,
    input  logic [2:0]                   lane_lg,
    input  logic [2:0]                   lanes_lg,
    input  logic [2:0]                   sub_lg,
    output logic [MAX_BUS_BYTES*8-1:0]   data
);
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int SUBW   = MAX_BUS_BYTES / WORD_BYTES;

    logic [WORD_W-1:0] one, rep;
    int unsigned       lane_bits;

    always_comb begin
        lane_bits = 32'd8 << lane_lg;
        one = {{(WORD_W-8){1'b0}}, cmd} << (big_end ? (lane_bits - 32'd8) : 32'd0);
        rep = one;
        if (lanes_lg >= 3'd3) rep = rep | (rep << (lane_bits * 4));
        if (lanes_lg >= 3'd2) rep = rep | (rep << (lane_bits * 2));
        if (lanes_lg >= 3'd1) rep = rep | (rep << lane_bits);
    end

    for (genvar k = 0; k < SUBW; k++) begin : g_sub
        assign data[k*WORD_W +: WORD_W] = (32'(k) < (32'd1 << sub_lg)) ? rep : '0;
    end
endmodule

// File: rtl/fcf_stat.sv
module fcf_stat #(
    parameter int MAX_BUS_BYTES = 16,
    parameter int WORD_BYTES    = 8
) (
    input  logic [MAX_BUS_BYTES*8-1:0] st_in,
    input  logic                       big_end,
    input  logic [2:0]                 bus_lg,
    input  logic [2:0]                 lane_lg,
    input  logic [2:0]                 lanes_lg,
    input  logic [2:0]                 sub_lg,
    output logic [WORD_BYTES*8-1:0]    st_out
);
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int BUS_W  = MAX_BUS_BYTES * 8;
    localparam int SUBW   = MAX_BUS_BYTES / WORD_BYTES;

    logic [BUS_W-1:0]  masked;
    logic [WORD_W-1:0] one, res;
    int unsigned       lane_bits;

    always_comb begin
        for (int j = 0; j < MAX_BUS_BYTES; j++)
            masked[j*8 +: 8] = (j < (1 << bus_lg)) ? st_in[j*8 +: 8] : 8'h00;
        one = '0;
        for (int k = 0; k < SUBW; k++)
            if (k < (1 << sub_lg)) one = one | masked[k*WORD_W +: WORD_W];
        lane_bits = 32'd8 << lane_lg;
        res = one;
        if (lanes_lg >= 3'd3) res = res | (one >> (lane_bits * 4));
        if (lanes_lg >= 3'd2) res = res | (one >> (lane_bits * 2));
        if (lanes_lg >= 3'd1) res = res | (one >> lane_bits);
        case (lane_lg)
            3'd1:    st_out = big_end ? WORD_W'({res[7:0], res[15:8]})
                                      : WORD_W'(res[15:0]);
            3'd2:    st_out = big_end ? WORD_W'({res[7:0], res[15:8], res[23:16], res[31:24]})
                                      : WORD_W'(res[31:0]);
            default: st_out = res;
        endcase
    end
endmodule

// File: rtl/flash_cmd_fmt.sv
module flash_cmd_fmt
    import fcf_pkg::*;
#(
    parameter int MAX_BUS_BYTES = 16,
    parameter int WORD_BYTES    = 8,
    parameter int OFS_W         = 16,
    parameter int ADDR_W        = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [7:0]                     cmd,
    input  logic [OFS_W-1:0]               cmd_ofs,
    input  logic [$clog2(MAX_BUS_BYTES):0] cfg_bus_bytes,
    input  logic [3:0]                     cfg_ilv,
    input  logic [2:0]                     cfg_dev_bytes,
    input  logic                           cfg_big_end,
    input  logic [MAX_BUS_BYTES*8-1:0]     status_in,
    output logic                           rsp_valid,
    output logic [ADDR_W-1:0]              addr_out,
    output logic [MAX_BUS_BYTES*8-1:0]     data_out,
    output logic [WORD_BYTES*8-1:0]        status_out,
    output logic                           geom_err
);
    localparam int BUS_W  = MAX_BUS_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;

    fcf_state_e        state, state_nx;
    logic              legal;
    logic [2:0]        bus_lg, ilv_lg, dev_lg, lane_lg, lanes_lg, sub_lg;
    logic [ADDR_W-1:0] addr_c;
    logic [BUS_W-1:0]  data_c;
    logic [WORD_W-1:0] stat_c;

    fcf_geom #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .WORD_BYTES(WORD_BYTES)) u_geom (
        .bus_bytes(cfg_bus_bytes), .ilv(cfg_ilv), .dev_bytes(cfg_dev_bytes),
        .legal(legal), .bus_lg(bus_lg), .ilv_lg(ilv_lg), .dev_lg(dev_lg),
        .lane_lg(lane_lg), .lanes_lg(lanes_lg), .sub_lg(sub_lg)
    );

    fcf_addr #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_addr (
        .ofs(cmd_ofs), .bus_lg(bus_lg), .ilv_lg(ilv_lg), .dev_lg(dev_lg), .addr(addr_c)
    );

    fcf_cmd #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .WORD_BYTES(WORD_BYTES)) u_cmd (
        .cmd(cmd), .big_end(cfg_big_end), .lane_lg(lane_lg), .lanes_lg(lanes_lg),
        .sub_lg(sub_lg), .data(data_c)
    );

    fcf_stat #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .WORD_BYTES(WORD_BYTES)) u_stat (
        .st_in(status_in), .big_end(cfg_big_end), .bus_lg(bus_lg), .lane_lg(lane_lg),
        .lanes_lg(lanes_lg), .sub_lg(sub_lg), .st_out(stat_c)
    );

    // next-state selection: accept / re-accept / retire
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nx = S_DONE;
            S_DONE: state_nx = req_valid ? S_DONE : S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    assign rsp_valid = (state == S_DONE);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_out   <= '0;
            data_out   <= '0;
            status_out <= '0;
            geom_err   <= 1'b0;
        end else if (req_valid) begin
            geom_err   <= !legal;
            addr_out   <= legal ? addr_c : '0;
            data_out   <= legal ? data_c : '0;
            status_out <= legal ? stat_c : '0;
        end
    end
endmodule

// File: rtl/flash_cmd_fmt_chk.sv
module flash_cmd_fmt_chk #(
    parameter int MAX_BUS_BYTES = 16,
    parameter int WORD_BYTES    = 8,
    parameter int ADDR_W        = 24
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic [$clog2(MAX_BUS_BYTES):0] cfg_bus_bytes,
    input logic                           rsp_valid,
    input logic [ADDR_W-1:0]              addr_out,
    input logic [MAX_BUS_BYTES*8-1:0]     data_out,
    input logic [WORD_BYTES*8-1:0]        status_out,
    input logic                           geom_err
);
    function automatic logic [MAX_BUS_BYTES*8-1:0] bus_mask(input logic [$clog2(MAX_BUS_BYTES):0] n);
        logic [MAX_BUS_BYTES*8-1:0] m;
        for (int j = 0; j < MAX_BUS_BYTES; j++)
            m[j*8 +: 8] = (j < int'(n)) ? 8'hFF : 8'h00;
        return m;
    endfunction

    // R2
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!rsp_valid && $stable(addr_out) && $stable(data_out)
                               && $stable(status_out) && $stable(geom_err)));

    // R5
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && geom_err) |-> (addr_out == '0 && data_out == '0 && status_out == '0));

    // R6
    above_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((data_out & ~bus_mask($past(cfg_bus_bytes))) == '0));
endmodule

bind flash_cmd_fmt flash_cmd_fmt_chk #(
    .MAX_BUS_BYTES(MAX_BUS_BYTES), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)
) u_fmt_chk (.*);

// File: tb/test_flash_cmd_fmt.sv
`timescale 1ns/1ps
module test_flash_cmd_fmt;
    localparam int MAXB   = 16;
    localparam int WB     = 8;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = 24;
    localparam int BUS_W  = MAXB * 8;
    localparam int WORD_W = WB * 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, req_valid, cfg_big_end;
    logic [7:0]        cmd;
    logic [OFS_W-1:0]  cmd_ofs;
    logic [4:0]        cfg_bus_bytes;
    logic [3:0]        cfg_ilv;
    logic [2:0]        cfg_dev_bytes;
    logic [BUS_W-1:0]  status_in;
    logic              rsp_valid, geom_err;
    logic [ADDR_W-1:0] addr_out;
    logic [BUS_W-1:0]  data_out;
    logic [WORD_W-1:0] status_out;

    flash_cmd_fmt #(.MAX_BUS_BYTES(MAXB), .WORD_BYTES(WB), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) i_flash_cmd_fmt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd(cmd), .cmd_ofs(cmd_ofs),
        .cfg_bus_bytes(cfg_bus_bytes), .cfg_ilv(cfg_ilv), .cfg_dev_bytes(cfg_dev_bytes),
        .cfg_big_end(cfg_big_end), .status_in(status_in), .rsp_valid(rsp_valid),
        .addr_out(addr_out), .data_out(data_out), .status_out(status_out), .geom_err(geom_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic              e_valid = 0, e_err = 0;
    logic [ADDR_W-1:0] e_addr = '0;
    logic [BUS_W-1:0]  e_data = '0;
    logic [WORD_W-1:0] e_stat = '0;
    string t_addr = "R2", t_data = "R2", t_stat = "R2", t_err = "R2";

    task automatic chk(input string tag, input string what, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_p2(input int x);
        return (x > 0) && ((x & (x - 1)) == 0);
    endfunction

    // behavioural reference for one accepted request
    task automatic model(input int bus, input int ilv, input int dev, input bit big,
                         input logic [7:0] c, input int ofs, input logic [BUS_W-1:0] st);
        bit ok;
        int lane, wordw, lanes, pos;
        longint unsigned s, r, a;
        ok = is_p2(bus) && bus <= MAXB && is_p2(ilv) && ilv <= 8 &&
             (dev == 1 || dev == 2 || dev == 4) && ilv <= bus && (bus / ilv) <= 4;
        e_err = !ok;
        t_err = "R5";
        if (!ok) begin
            e_addr = '0; e_data = '0; e_stat = '0;
            t_addr = "R5"; t_data = "R5"; t_stat = "R5";
            return;
        end
        lane  = bus / ilv;
        wordw = (bus > WB) ? WB : bus;
        lanes = wordw / lane;
        // address
        a = longint'(ofs) * dev * ilv;
        t_addr = "R3";
        if (dev * ilv > bus && (ofs & 255) == 'hAA) begin
            a = a | longint'((dev / 2) * ilv);
            t_addr = "R4";
        end
        e_addr = ADDR_W'(a);
        // command data: byte view
        pos = (big && lane > 1) ? lane - 1 : 0;
        e_data = '0;
        for (int j = 0; j < bus; j++)
            if ((j % lane) == pos) e_data[j*8 +: 8] = c;
        t_data = (big && lane > 1) ? "R7" : ((bus > WB) ? "R8" : "R6");
        // status
        s = 0;
        for (int j = 0; j < bus; j++)
            s = s | (longint'(st[j*8 +: 8]) << ((j % wordw) * 8));
        r = s;
        if (lanes >= 8) r = r | (s >> (lane * 32));
        if (lanes >= 4) r = r | (s >> (lane * 16));
        if (lanes >= 2) r = r | (s >> (lane * 8));
        if (lane == 2) begin
            r = r & 64'hFFFF;
            if (big) r = {48'd0, r[7:0], r[15:8]};
        end else if (lane == 4) begin
            r = r & 64'hFFFF_FFFF;
            if (big) r = {32'd0, r[7:0], r[15:8], r[23:16], r[31:24]};
        end
        e_stat = WORD_W'(r);
        t_stat = (bus > WB) ? "R11" : ((lane > 1) ? "R10" : "R9");
    endtask

    task automatic compare();
        chk("R2", "rsp_valid", BUS_W'(rsp_valid), BUS_W'(e_valid));
        chk(t_err, "geom_err", BUS_W'(geom_err), BUS_W'(e_err));
        chk(t_addr, "addr_out", BUS_W'(addr_out), BUS_W'(e_addr));
        chk(t_data, "data_out", data_out, e_data);
        chk(t_stat, "status_out", BUS_W'(status_out), BUS_W'(e_stat));
    endtask

    task automatic tick(input bit go, input int bus, input int ilv, input int dev, input bit big,
                        input logic [7:0] c, input int ofs, input logic [BUS_W-1:0] st);
        @(negedge clk);
        req_valid     = go;
        cfg_bus_bytes = 5'(bus);
        cfg_ilv       = 4'(ilv);
        cfg_dev_bytes = 3'(dev);
        cfg_big_end   = big;
        cmd           = c;
        cmd_ofs       = OFS_W'(ofs);
        status_in     = st;
        e_valid       = go;
        if (go) model(bus, ilv, dev, big, c, ofs, st);
        else begin
            t_addr = "R2"; t_data = "R2"; t_stat = "R2"; t_err = "R2";
        end
        @(posedge clk);
        #1;
        compare();
    endtask

    function automatic logic [BUS_W-1:0] rnd_bus();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int bl[7], il[5], dl[4];
        bl = '{1, 2, 4, 8, 16, 3, 12};
        il = '{1, 2, 4, 8, 5};
        dl = '{1, 2, 4, 3};
        rst_n = 0; req_valid = 0; cmd = '0; cmd_ofs = '0; cfg_bus_bytes = 5'd1;
        cfg_ilv = 4'd1; cfg_dev_bytes = 3'd1; cfg_big_end = 0; status_in = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "rsp_valid", BUS_W'(rsp_valid), '0);
        chk("R1", "geom_err", BUS_W'(geom_err), '0);
        chk("R1", "addr_out", BUS_W'(addr_out), '0);
        chk("R1", "data_out", data_out, '0);
        chk("R1", "status_out", BUS_W'(status_out), '0);
        @(negedge clk);
        rst_n = 1;

        // R3 plain single device
        tick(1, 1, 1, 1, 0, 8'h98, 'h55, rnd_bus());
        // R6 / R10 2-byte lane, little then big (R7)
        tick(1, 2, 1, 2, 0, 8'h98, 'h55, rnd_bus());
        tick(1, 2, 1, 2, 1, 8'h98, 'h55, rnd_bus());
        // R4 compatibility twist: 16-bit part on 8-bit bus
        tick(1, 1, 1, 2, 0, 8'hAA, 'h2AA, rnd_bus());
        // R3 no twist: device width times interleave equals bus width
        tick(1, 4, 2, 2, 0, 8'h55, 'hAA, rnd_bus());
        tick(0, 8, 8, 1, 1, 8'h00, 'h1234, rnd_bus());
        // R9 eight 1-byte lanes
        tick(1, 8, 8, 1, 0, 8'hF0, 'h0, 128'h0000_0000_0000_0000_0102_0408_1020_4080);
        // R8 / R11 wide bus with 4-byte lanes, big-endian (R7, R10)
        tick(1, 16, 4, 4, 1, 8'h70, 'h5555, rnd_bus());
        tick(1, 16, 8, 2, 0, 8'hFF, 'h2AAA, rnd_bus());
        // R11 bytes above a 4-byte bus ignored
        tick(1, 4, 4, 1, 0, 8'h90, 'h10, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000_0100);
        // R5 illegal geometries
        tick(1, 3, 1, 1, 0, 8'h98, 'h55, rnd_bus());
        tick(1, 4, 8, 1, 0, 8'h98, 'h55, rnd_bus());
        tick(1, 16, 1, 4, 0, 8'h98, 'h55, rnd_bus());
        tick(1, 2, 1, 3, 0, 8'h98, 'h55, rnd_bus());
        // R2 hold with changing inputs, then back-to-back strobes
        tick(0, 2, 2, 1, 1, 8'h11, 'hAA, rnd_bus());
        tick(0, 8, 2, 4, 0, 8'h22, 'h3, rnd_bus());
        tick(1, 8, 2, 4, 1, 8'h33, 'h4AA, rnd_bus());
        tick(1, 8, 4, 2, 0, 8'h44, 'hAA, rnd_bus());

        for (int n = 0; n < 400; n++) begin
            int ofs;
            ofs = ($urandom % 4 == 0) ? int'(($urandom & 'hFF00) | 'hAA) : int'($urandom & 'hFFFF);
            tick(($urandom % 4) != 0, bl[$urandom % 7], il[$urandom % 5], dl[$urandom % 4],
                 1'($urandom), 8'($urandom), ofs, rnd_bus());
        end
        tick(0, 1, 1, 1, 0, 8'h00, 0, '0);

        finished = 1;
        summary();
        $finish;
    end
endmodule